// File: doc/BRIEF.md
# External Bus Chip-Select Timing Sequencer

This block turns one internal read or write request into a timed cycle on an external memory bus. At the start of each cycle it presents the address and raises the address-latch strobe for one clock. Chip-select follows after a programmable setup interval and stays low through a programmable number of wait states. In the last chip-select clock the block raises an internal transfer acknowledge. After the final beat, the address (and, on writes, the data) is held for a programmable interval. Read holds and write holds use different encodings.

The timing of a region comes from a 32-bit control word, which is sampled when a request is accepted. The fields are: setup in bits [21:20], read hold in [19:18], write hold in [17:16], wait states in [15:10], multiplexed mode in bit 9 and auto-acknowledge in bit 8. In multiplexed mode the low port lanes carry the address only during the strobe clock and carry data afterwards. A transfer wider than the port is then split into port-width beats in increasing address order. The read result is assembled from those beats.

Top module: `ebus_cs_seq`

## Requirements
- R1: `bus_ale` is high for exactly one clock at the start of every beat, with `bus_cs_n` high in that clock and `bus_ad_out` carrying the full beat address.
- R2: With setup field value S (0..3), `bus_cs_n` first goes low S+1 clocks after the strobe clock.
- R3: With wait-state field value W (0..63), `bus_cs_n` stays low for W+1 clocks. `xfer_ack` is high only in the last of those clocks, and only on the final beat.
- R4: On a read, after `bus_cs_n` rises on the final beat, the address stays on `bus_ad_out` with `busy` high for H clocks, H being the read-hold field (0..3). Then `busy` falls and the bus goes quiet: all outputs zero, `bus_cs_n` and `bus_rnw` high.
- R5: On a write, the hold lasts H+1 clocks, H being the write-hold field. Address and write data stay driven throughout the hold.
- R6: In multiplexed mode (bit 9 = 1), a transfer of B bytes (size code 0 = 1, 1 = 2, 2 or 3 = 4) on a port of P bytes runs max(1, B/P) beats. Beat k uses address base+k*P. The low P*8 lanes of `bus_ad_out` carry the address in the strobe clock. After that they carry write lane k (bits [k*P*8 +: P*8] of the write data) with `bus_ad_lo_oe` high, or, on reads, zero with `bus_ad_lo_oe` low.
- R7: Hold time is inserted only after the final beat: the strobe of the next beat follows directly after the clock in which `bus_cs_n` rises.
- R8: On a multiplexed read, `rd_data` in the acknowledge clock holds beat k's `bus_lo_in` in bits [k*P*8 +: P*8], with zeros above the last beat. On a non-multiplexed read it equals `bus_d_in`. In non-multiplexed writes, `bus_d_out` carries the write data with `bus_d_oe` high for the whole busy period.
- R9: A request is accepted only while `busy` is low. A request raised while busy is ignored and starts no later cycle.
- R10: A change of `ctl_word` after acceptance does not affect the transfer in progress.
- R11: The auto-acknowledge bit (bit 8) must be 1 whenever a request is accepted; termination is always internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 32 | Region timing control word |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Sequencer not idle |
| xfer_ack | output | 1 | Internal transfer acknowledge |
| rd_data | output | DW | Read result, valid with acknowledge |
| bus_ale | output | 1 | Address-latch strobe |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rnw | output | 1 | Direction attribute, 1 = read |
| bus_ad_out | output | AW | Address / multiplexed data lines |
| bus_ad_lo_oe | output | 1 | Drive enable for low port lanes |
| bus_lo_in | input | P*8 | Low port lanes, read data in multiplexed mode |
| bus_d_out | output | DW | Separate data lines, write data |
| bus_d_oe | output | 1 | Drive enable for separate data lines |
| bus_d_in | input | DW | Separate data lines, read data |

## Verification
Two events can fall in the same clock. The acknowledge clock of the last beat also decides whether the sequencer goes idle, holds, or starts the next beat's strobe. A stray request can also coincide with a busy clock, including the final hold clock. The bench runs zero-length and maximal hold settings, multi-beat multiplexed transfers, and a stray request together with a control-word change placed mid-transfer. A behavioural model predicts each clock's outputs, including the idle clock that follows. Any early acceptance, an extra strobe, or a misplaced hold therefore shows up as a mismatch on the very clock it occurs.

// File: rtl/ebus_cs_seq.sv
module ebus_cs_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ctl_word,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          xfer_ack,
  output logic [DW-1:0] rd_data,
  output logic          bus_ale,
  output logic          bus_cs_n,
  output logic          bus_rnw,
  output logic [AW-1:0] bus_ad_out,
  output logic          bus_ad_lo_oe,
  input  logic [8*PB-1:0] bus_lo_in,
  output logic [DW-1:0] bus_d_out,
  output logic          bus_d_oe,
  input  logic [DW-1:0] bus_d_in
);
  localparam int PW = 8 * PB;

  typedef enum logic [2:0] {S_IDLE, S_ALE, S_SETUP, S_CS, S_HOLD} st_t;

  st_t           st;
  logic [5:0]    cnt;
  logic [1:0]    beat, last_beat;
  logic [AW-1:0] base;
  logic [DW-1:0] wdat, acc;
  logic          wr, mux;
  logic [1:0]    setup, rdah, wrah;
  logic [5:0]    ws;

  wire       accept    = req_valid && st == S_IDLE;
  wire [2:0] req_bytes = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  wire [2:0] req_beats = (ctl_word[9] && req_bytes > 3'(PB)) ? req_bytes / 3'(PB) : 3'd1;
  wire [2:0] hold_len  = wr ? {1'b0, wrah} + 3'd1 : {1'b0, rdah};
  wire       beat_end  = st == S_CS && cnt == 6'd0;
  wire       fin       = beat_end && beat == last_beat;

  wire [AW-1:0] beat_addr = base + AW'(beat) * AW'(PB);
  wire [DW-1:0] wshift    = wdat >> (32'(beat) * PW);
  wire [PW-1:0] wlane     = wshift[PW-1:0];
  wire [DW-1:0] lane_mask = DW'({PW{1'b1}}) << (32'(beat) * PW);
  wire [DW-1:0] lane_in   = DW'(bus_lo_in) << (32'(beat) * PW);
  wire [DW-1:0] merged    = (acc & ~lane_mask) | lane_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; beat <= '0; last_beat <= '0;
      base <= '0; wdat <= '0; acc <= '0; wr <= 1'b0; mux <= 1'b0;
      setup <= '0; rdah <= '0; wrah <= '0; ws <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st <= S_ALE; beat <= '0; last_beat <= 2'(req_beats - 3'd1);
          base <= req_addr; wdat <= req_wdata; wr <= req_write; acc <= '0;
          setup <= ctl_word[21:20]; rdah <= ctl_word[19:18]; wrah <= ctl_word[17:16];
          ws <= ctl_word[15:10]; mux <= ctl_word[9];
        end
        S_ALE: begin
          st  <= (setup == 2'd0) ? S_CS : S_SETUP;
          cnt <= (setup == 2'd0) ? ws : 6'(setup - 2'd1);
        end
        S_SETUP: begin
          if (cnt == 6'd0) begin st <= S_CS; cnt <= ws; end
          else cnt <= cnt - 6'd1;
        end
        S_CS: begin
          if (cnt != 6'd0) cnt <= cnt - 6'd1;
          else begin
            acc <= merged;
            if (!fin) begin st <= S_ALE; beat <= beat + 2'd1; end
            else if (hold_len == 3'd0) st <= S_IDLE;
            else begin st <= S_HOLD; cnt <= 6'(hold_len - 3'd1); end
          end
        end
        S_HOLD: begin
          if (cnt == 6'd0) st <= S_IDLE;
          else cnt <= cnt - 6'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy         = st != S_IDLE;
  assign xfer_ack     = fin;
  assign bus_ale      = st == S_ALE;
  assign bus_cs_n     = st != S_CS;
  assign bus_rnw      = busy ? !wr : 1'b1;
  assign bus_ad_lo_oe = busy && (!mux || st == S_ALE || wr);
  assign bus_d_oe     = busy && !mux && wr;
  assign bus_d_out    = bus_d_oe ? wdat : '0;
  assign rd_data      = mux ? merged : bus_d_in;

  always_comb begin
    bus_ad_out = '0;
    if (busy) begin
      bus_ad_out = beat_addr;
      if (mux && st != S_ALE) bus_ad_out[PW-1:0] = wr ? wlane : '0;
    end
  end

  logic [3:0] since_ale;
  logic [6:0] cs_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ale <= '0; cs_len <= '0;
    end else begin
      since_ale <= bus_ale ? 4'd1 : (since_ale == 4'hF ? since_ale : since_ale + 4'd1);
      cs_len    <= bus_cs_n ? 7'd0 : cs_len + 7'd1;
    end
  end

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bus_ale |=> !bus_ale); // R1
  AST_ALE_CS_APART: assert property (@(posedge clk) disable iff (!rst_n) bus_ale |-> bus_cs_n); // R1
  AST_SETUP_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> since_ale == 4'(setup) + 4'd1); // R2
  AST_WAIT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> cs_len == 7'(ws) + 7'd1); // R3
  AST_ACK_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) xfer_ack |-> !bus_cs_n); // R3
  AST_ACK_ENDS_CS: assert property (@(posedge clk) disable iff (!rst_n) xfer_ack |=> bus_cs_n); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(base) && $stable(wdat)); // R9
  AST_AUTOACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |-> ctl_word[8]); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_cs_n && !bus_ale && !xfer_ack && !bus_ad_lo_oe); // R4
endmodule

// File: tb/ebus_cs_seq_test.sv
`timescale 1ns/100ps
module ebus_cs_seq_test;
  localparam int PB = 2;
  localparam int PW = 8 * PB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ctl_word = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_d_in = '0;
  logic [1:0] req_size = '0;
  logic [PW-1:0] bus_lo_in = '0;
  logic busy, xfer_ack, bus_ale, bus_cs_n, bus_rnw, bus_ad_lo_oe, bus_d_oe;
  logic [31:0] rd_data, bus_ad_out, bus_d_out;

  always #2.5 clk = ~clk;

  ebus_cs_seq #(.AW(32), .DW(32), .PB(PB)) uut (
    .clk, .rst_n, .ctl_word, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
    .busy, .xfer_ack, .rd_data, .bus_ale, .bus_cs_n, .bus_rnw, .bus_ad_out, .bus_ad_lo_oe,
    .bus_lo_in, .bus_d_out, .bus_d_oe, .bus_d_in);

  typedef struct packed {
    logic ale, cs_n, ack, busy, lo_oe, d_oe;
    logic [31:0] ad;
    logic [1:0] beat;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;

  function automatic logic [31:0] mk(int s, int rh, int wh, int w, int mx);
    logic [31:0] c = '0;
    c[21:20] = 2'(s); c[19:18] = 2'(rh); c[17:16] = 2'(wh);
    c[15:10] = 6'(w); c[9] = 1'(mx); c[8] = 1'b1;
    return c;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic build(logic [31:0] cfg, logic w, logic [31:0] a0, int size, logic [31:0] wd);
    int bytes = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    int mx = cfg[9];
    int beats = (mx != 0 && bytes > PB) ? bytes / PB : 1;
    int hold = w ? int'(cfg[17:16]) + 1 : int'(cfg[19:18]);
    exp_t e;
    logic [31:0] adx = '0;
    q.delete();
    for (int b = 0; b < beats; b++) begin
      logic [31:0] a = a0 + ((mx != 0) ? 32'(b * PB) : 32'd0);
      adx = a;
      if (mx != 0) adx[PW-1:0] = w ? PW'(wd >> (b * PW)) : '0;
      e = '{ale:1, cs_n:1, ack:0, busy:1, lo_oe:1, d_oe:(w && mx == 0), ad:a, beat:2'(b)};
      q.push_back(e);
      e.ale = 0; e.ad = adx; e.lo_oe = (mx == 0) || w;
      for (int i = 0; i < int'(cfg[21:20]); i++) q.push_back(e);
      e.cs_n = 0;
      for (int i = 0; i <= int'(cfg[15:10]); i++) begin
        e.ack = (i == int'(cfg[15:10])) && (b == beats - 1);
        q.push_back(e);
      end
    end
    e.cs_n = 1; e.ack = 0;
    for (int i = 0; i < hold; i++) q.push_back(e);
    e = '{ale:0, cs_n:1, ack:0, busy:0, lo_oe:0, d_oe:0, ad:0, beat:e.beat};
    q.push_back(e);
  endtask

  task automatic xfer(string tag, logic [31:0] cfg, logic w, logic [31:0] a0, int size,
                      logic [31:0] wd, logic [31:0] rimg, bit stray);
    int bytes = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    int beats = (cfg[9] && bytes > PB) ? bytes / PB : 1;
    logic [31:0] rexp;
    int n = 0;
    rexp = cfg[9] ? ((beats * PW >= 32) ? rimg : rimg & ((32'd1 << (beats * PW)) - 1)) : rimg;
    build(cfg, w, a0, size, wd);
    @(negedge clk);
    ctl_word = cfg; req_valid = 1'b1; req_write = w; req_addr = a0;
    req_size = 2'(size); req_wdata = wd; bus_d_in = rimg;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      bus_lo_in = PW'(rimg >> (32'(e.beat) * PW));
      if (stray && n == 2) begin
        req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_wdata = 32'h5555_AAAA;
        ctl_word = mk(0, 0, 0, 0, 0);
      end
      if (stray && q.size() == 1) req_valid = 1'b1;
      if (stray && q.size() == 0) req_valid = 1'b0;
      #1;
      chk({tag, " R1 ale"}, "bus_ale", 32'(bus_ale), 32'(e.ale));
      chk({tag, " R2 R3 cs"}, "bus_cs_n", 32'(bus_cs_n), 32'(e.cs_n));
      chk({tag, " R3 ack"}, "xfer_ack", 32'(xfer_ack), 32'(e.ack));
      chk({tag, " R4 R5 R9 busy"}, "busy", 32'(busy), 32'(e.busy));
      chk({tag, " R6 lanes"}, "bus_ad_out", bus_ad_out, e.ad);
      chk({tag, " R6 oe"}, "bus_ad_lo_oe", 32'(bus_ad_lo_oe), 32'(e.lo_oe));
      chk({tag, " R8 doe"}, "bus_d_oe", 32'(bus_d_oe), 32'(e.d_oe));
      chk({tag, " R5 rnw"}, "bus_rnw", 32'(bus_rnw), e.busy ? 32'(!w) : 32'd1);
      if (e.d_oe) chk({tag, " R5 R8 wdata"}, "bus_d_out", bus_d_out, wd);
      if (e.ack && !w) chk({tag, " R8 rdata"}, "rd_data", rd_data, rexp);
      n++;
      if (q.size() > 0) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset", "busy", 32'(busy), 32'd0);
    chk("R1 reset", "bus_ale", 32'(bus_ale), 32'd0);
    chk("R2 reset", "bus_cs_n", 32'(bus_cs_n), 32'd1);
    chk("R3 reset", "xfer_ack", 32'(xfer_ack), 32'd0);
    rst_n = 1'b1;
    xfer("R4 R11 nmx-rd-min", mk(0, 0, 0, 0, 0), 1'b0, 32'h1000_0040, 2, 0, 32'hCAFE_F00D, 0);
    xfer("R2 R5 nmx-wr-s3", mk(3, 0, 0, 2, 0), 1'b1, 32'h2000_0010, 2, 32'h1234_5678, 0, 0);
    xfer("R5 nmx-wr-h4", mk(1, 2, 3, 1, 0), 1'b1, 32'h2000_0020, 0, 32'h0000_00A5, 0, 0);
    xfer("R3 R4 nmx-rd-w63", mk(2, 3, 0, 63, 0), 1'b0, 32'h3000_0000, 1, 0, 32'h0BAD_BEEF, 0);
    xfer("R6 R7 mx-wr-long", mk(1, 0, 1, 1, 1), 1'b1, 32'h4000_0100, 2, 32'hA1B2_C3D4, 0, 0);
    xfer("R6 R7 R8 mx-rd-long", mk(0, 2, 0, 3, 1), 1'b0, 32'h4000_0200, 3, 0, 32'h8765_4321, 0);
    xfer("R8 mx-rd-byte", mk(2, 1, 2, 0, 1), 1'b0, 32'h4000_0301, 0, 0, 32'h0000_9A7E, 0);
    xfer("R6 mx-wr-word", mk(3, 3, 2, 4, 1), 1'b1, 32'h4000_0402, 1, 32'h0000_77EE, 0, 0);
    xfer("R9 R10 stray", mk(2, 1, 3, 5, 1), 1'b1, 32'h5000_0000, 2, 32'hFEED_C0DE, 0, 1);
    xfer("R9 R10 stray-rd", mk(1, 3, 0, 2, 0), 1'b0, 32'h5000_0040, 2, 0, 32'h1357_9BDF, 1);
    xfer("R1 R7 mx-rd-s0", mk(0, 0, 0, 0, 1), 1'b0, 32'h6000_0000, 2, 0, 32'hFFFF_0001, 0);
    summary();
    $finish;
  end
endmodule